// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit-Slip Word Alignment

This block takes one bit per fast-clock cycle from a serial line and produces a parallel word of `WORD_W` bits, with a one-cycle strobe, once every `WORD_W` cycles. The serial input is registered straight on the rising clock edge. No phase picking or elastic buffering happens ahead of the shift path.

Downstream framing logic moves the word boundary with a slip request when it sees misaligned words. Each accepted request holds the framing counter for one extra cycle. This shifts every later word by one serial bit. A counter records how many slips have been applied. When that count would reach the preset rollover value, it returns to zero and a rollover flag pulses for one cycle. Framing logic can therefore tell that it has tried every boundary position.

Top module: `deser_bitslip`

## Requirements
- R1: While `rst_ni` is low, and directly after it, `valid_o` and `slip_max_o` are 0 and `slip_cnt_o` is 0.
- R2: When `valid_o` is high after clock edge e, `word_o` holds the `ser_i` values sampled on edges e-WORD_W through e-1. The earliest of these bits is in bit WORD_W-1 (MSB) and the latest is in bit 0.
- R3: `valid_o` is a single-cycle pulse. With no slip pending, consecutive pulses are exactly `WORD_W` cycles apart.
- R4: Each accepted slip produces exactly one gap of `WORD_W`+1 cycles between consecutive `valid_o` pulses. This delays the word boundary by one serial bit.
- R5: A slip request is a 0-to-1 transition of `slip_i` after a two-flop synchronizer. Holding `slip_i` high counts as a single request.
- R6: A request that arrives while an earlier accepted slip has not yet taken effect is dropped. It changes neither the gap pattern nor `slip_cnt_o`.
- R7: `slip_cnt_o` goes up by one for each applied slip. It stays below `ROLL_CNT` and wraps to 0 on the `ROLL_CNT`-th slip.
- R8: On a wrap, `slip_max_o` is high for exactly one cycle, in the same cycle in which `slip_cnt_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (bit-rate) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data bit |
| slip_i | input | 1 | Slip request level; a rising edge asks for a one-bit shift |
| word_o | output | WORD_W | Parallel word, earliest bit in MSB |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| slip_cnt_o | output | CNT_W | Applied slips modulo ROLL_CNT |
| slip_max_o | output | 1 | One-cycle pulse on counter rollover |

## Verification
The hardest situation to reach is a second slip request landing while the first is still pending. That window only lasts until the framing counter reaches its last position. The bench waits for a `valid_o` strobe to learn the framing phase. It then sends two short pulses four cycles apart, so the second is synchronized before the counter stalls. The rollover pulse is reached by running the slip table past `ROLL_CNT` twice. A held-high `slip_i` tests edge detection.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int unsigned MIN_WORD_W = 3;
  localparam int unsigned MAX_WORD_W = 10;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/deser_slip_sync.sv
module deser_slip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slip_i,
  output logic req_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], slip_i};
  end

  // rising edge after synchronization
  assign req_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/deser_framer.sv
module deser_framer #(
  parameter int unsigned WORD_W = 10,
  localparam int unsigned IDX_W = deser_pkg::idx_width(WORD_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic emit_o,
  output logic apply_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             last;

  assign last    = (cnt_q == LAST);
  assign apply_o = pend_q & last;
  assign emit_o  = last & ~pend_q;

  always_comb begin
    if (apply_o)   cnt_d = cnt_q;          // stall one bit
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (apply_o)    pend_d = 1'b0;         // a request in this cycle is dropped
    else if (req_i) pend_d = 1'b1;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/deser_slip_cnt.sv
module deser_slip_cnt #(
  parameter int unsigned ROLL_CNT = 10,
  localparam int unsigned CNT_W = deser_pkg::idx_width(ROLL_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             max_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(ROLL_CNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             max_q;
  logic             wrap;

  assign wrap = apply_i & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      max_q <= 1'b0;
    end else begin
      max_q <= wrap;
      if (wrap)         cnt_q <= '0;
      else if (apply_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign max_o = max_q;
endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip #(
  parameter int unsigned WORD_W      = 10,
  parameter int unsigned ROLL_CNT    = WORD_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = deser_pkg::idx_width(ROLL_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              slip_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  slip_cnt_o,
  output logic              slip_max_o
);
  logic              ser_q;
  logic [WORD_W-2:0] sr_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic              req, emit, apply;

  initial begin
    if (WORD_W < deser_pkg::MIN_WORD_W || WORD_W > deser_pkg::MAX_WORD_W)
      $error("WORD_W out of range");
    if (ROLL_CNT < 2) $error("ROLL_CNT below 2");
  end

  deser_slip_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .slip_i(slip_i), .req_o(req)
  );

  deser_framer #(.WORD_W(WORD_W)) framer_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(req),
    .emit_o(emit), .apply_o(apply)
  );

  deser_slip_cnt #(.ROLL_CNT(ROLL_CNT)) cnt_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .apply_i(apply),
    .cnt_o (slip_cnt_o), .max_o(slip_max_o)
  );

  // earliest bit migrates to the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q   <= 1'b0;
      sr_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ser_q   <= ser_i;
      sr_q    <= {sr_q[WORD_W-3:0], ser_q};
      valid_q <= emit;
      if (emit) word_q <= {sr_q, ser_q};
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/deser_bitslip_chk.sv
module deser_bitslip_chk #(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned ROLL_CNT = 10,
  parameter int unsigned CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic [CNT_W-1:0] slip_cnt_o,
  input logic             slip_max_o
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_o) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hff) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (gap_q == 8'(WORD_W) || gap_q == 8'(WORD_W + 1)));

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_cnt_o < CNT_W'(ROLL_CNT));

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(slip_cnt_o) |-> (slip_cnt_o == $past(slip_cnt_o) + 1'b1) || slip_max_o);

  // R8
  max_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_max_o |-> slip_cnt_o == '0);

  // R8
  max_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_max_o |=> !slip_max_o);
endmodule

bind deser_bitslip deser_bitslip_chk #(
  .WORD_W(WORD_W), .ROLL_CNT(ROLL_CNT), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_o(valid_o),
  .slip_cnt_o(slip_cnt_o), .slip_max_o(slip_max_o)
);

// File: tb/deser_bitslip_tb_top.sv
module deser_bitslip_tb_top;
  localparam int N    = 10;
  localparam int ROLL = 10;
  localparam int CW   = 4;
  localparam int NVEC = 8;

  // [10:9] data mode (0 lfsr, 1 ones, 2 alternating), [8:5] slips,
  // [4:1] expected count afterwards, [0] rollover pulse expected
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 4'd3, 4'd3, 1'b0},
    {2'd1, 4'd0, 4'd3, 1'b0},
    {2'd2, 4'd4, 4'd7, 1'b0},
    {2'd0, 4'd2, 4'd9, 1'b0},
    {2'd0, 4'd1, 4'd0, 1'b1},
    {2'd1, 4'd5, 4'd5, 1'b0},
    {2'd2, 4'd5, 4'd0, 1'b1},
    {2'd0, 4'd0, 4'd0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ser_i = 1'b0;
  logic          slip_i = 1'b0;
  logic [N-1:0]  word_o;
  logic          valid_o;
  logic [CW-1:0] slip_cnt_o;
  logic          slip_max_o;

  int errors = 0, checks = 0, cycles = 0, ec = 0;
  int gap = 0, long_gaps = 0, max_pulses = 0;
  bit seen = 0, max_prev = 0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] lfsr = 16'hace1;
  logic        hist [4096];

  always #10 clk = ~clk;

  deser_bitslip #(.WORD_W(N), .ROLL_CNT(ROLL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser_i), .slip_i(slip_i),
    .word_o(word_o), .valid_o(valid_o),
    .slip_cnt_o(slip_cnt_o), .slip_max_o(slip_max_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    hist[ec % 4096] = ser_i;
    ec++;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // serial source
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      2'd1:    ser_i <= 1'b1;
      2'd2:    ser_i <= ~ser_i;
      default: ser_i <= lfsr[0];
    endcase
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst_ni) begin
      seen = 0; gap = 0; max_prev = 0;
    end else begin
      gap++;
      if (valid_o) begin
        if (seen) begin
          logic [N-1:0] exp;
          for (int i = 0; i < N; i++) exp[N-1-i] = hist[(ec - 1 - N + i) % 4096];
          check("R2 word", int'(word_o), int'(exp));
          if (gap == N + 1) long_gaps++;
          else if (gap != N) check("R3 gap", gap, N);
        end
        seen = 1; gap = 0;
      end
      if (slip_max_o && !max_prev) max_pulses++;
      if (slip_max_o && max_prev) check("R8 max width", 2, 1);
      max_prev = slip_max_o;
    end
  end

  task automatic wait_valid();
    do @(negedge clk); while (!valid_o);
  endtask

  task automatic pulse_slip();
    wait_valid();
    slip_i = 1'b1;
    repeat (2) @(negedge clk);
    slip_i = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int lg0, mp0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid", int'(valid_o), 0);
    check("R1 cnt", int'(slip_cnt_o), 0);
    check("R1 max", int'(slip_max_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 cnt after release", int'(slip_cnt_o), 0);
    repeat (3 * N) @(negedge clk);

    // R2 R3 R4 R7 R8 table
    for (int v = 0; v < NVEC; v++) begin
      mode = VEC[v][10:9];
      lg0 = long_gaps; mp0 = max_pulses;
      for (int s = 0; s < int'(VEC[v][8:5]); s++) pulse_slip();
      repeat (3 * N) @(negedge clk);
      check("R4 long gaps", long_gaps - lg0, int'(VEC[v][8:5]));
      check("R7 count", int'(slip_cnt_o), int'(VEC[v][4:1]));
      check("R8 pulses", max_pulses - mp0, int'(VEC[v][0]));
    end

    // R5: held level is one request
    mode = 2'd0;
    lg0 = long_gaps;
    wait_valid();
    slip_i = 1'b1;
    repeat (60) @(negedge clk);
    slip_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R5 count", int'(slip_cnt_o), 1);
    check("R5 long gaps", long_gaps - lg0, 1);

    // R6: second edge while the first is pending
    lg0 = long_gaps;
    wait_valid();
    slip_i = 1'b1;
    repeat (2) @(negedge clk);
    slip_i = 1'b0;
    repeat (2) @(negedge clk);
    slip_i = 1'b1;
    repeat (2) @(negedge clk);
    slip_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R6 count", int'(slip_cnt_o), 2);
    check("R6 long gaps", long_gaps - lg0, 1);

    // R1 mid-run reset
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset cnt", int'(slip_cnt_o), 0);
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset max", int'(slip_max_o), 0);
    rst_ni = 1'b1;
    repeat (3 * N) @(negedge clk);
    check("R3 running after reset", int'(seen), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule